// File: doc/BRIEF.md
# Phase-Error Lock Detector

This block judges whether a phase-locked loop is in lock by timing every phase-error pulse that its phase comparator emits. The pulse is first brought into the local clock domain through a short flop chain. Its width is then counted in cycles of a sampling clock whose period is known at design time. A 2-bit width-select input chooses one of four modes. Stop mode keeps the detector idle. Pass-through mode forwards the synchronised error pulse unchanged. Two tolerance modes flag only pulses wider than a narrow (about 0.55 µs) or a wide (about 1.11 µs) limit.

In the tolerance modes, a flagged error is not shown for its own short length. It starts a retriggerable hold that keeps the unlock flag up for one to two periods of a slow tick, which is about 1 to 2 ms with the default parameters. Each new over-limit error restarts the hold. The block drives an active-high unlock flag for a pin and a lock status bit for serial read-back. The status bit is 1 while locked and 0 while unlocked.

Two small state machines carry the behaviour. The width meter has three states. IDLE goes to MEASURE on the first high sample. MEASURE goes back to IDLE when the pulse ends within the limit, or to OVER (raising a one-cycle violation strobe) on the sample after the limit is reached. OVER waits there until the pulse ends and then returns to IDLE. The stretcher has two states. QUIET goes to HOLD on a violation. In HOLD a violation reloads the tick budget, each slow tick spends one unit, and spending the last unit returns it to QUIET. Leaving the tolerance modes forces both machines back to their rest states (IDLE and QUIET).

Top module: `phase_lock_detector`

## Requirements
- R1: With width-select 2'b00 (stop), unlock_o stays 0 and lock_status_o stays 1 whatever the error input does. Entering stop mode during a hold ends the hold, so no unlock appears after a later return to a tolerance mode without a new error.
- R2: With width-select 2'b01 (pass-through), unlock_o repeats phase_err_i two clock cycles late, with the same width in cycles, and no stretching.
- R3: With width-select 2'b10 (narrow), an error pulse of at most NARROW_TOL_PS/CLK_PERIOD_PS cycles (55 by default) causes no unlock. One cycle longer causes an unlock.
- R4: With width-select 2'b11 (wide), an error pulse of at most WIDE_TOL_PS/CLK_PERIOD_PS cycles (111 by default) causes no unlock. One cycle longer causes an unlock.
- R5: In a tolerance mode, a single over-limit error holds unlock_o high for between (STRETCH_TICKS-1)*TICK_DIV+1 and STRETCH_TICKS*TICK_DIV consecutive cycles.
- R6: A further over-limit error during a hold restarts the full hold, which extends the unlock beyond the single-error length.
- R7: lock_status_o is the inverse of unlock_o in every mode and cycle.
- R8: During and right after reset, unlock_o is 0 and lock_status_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock of period CLK_PERIOD_PS |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_err_i | input | 1 | Phase-error pulse from the comparator, asynchronous |
| width_sel_i | input | 2 | 00 stop, 01 pass-through, 10 narrow limit, 11 wide limit |
| unlock_o | output | 1 | High while the loop is judged unlocked |
| lock_status_o | output | 1 | Read-back status: 1 locked, 0 unlocked |

## Verification
The assertions take for granted that width_sel_i changes only on whole clock cycles. They also assume that phase_err_i, though asynchronous in principle, is stable around sampling edges, so that each pulse spans a whole number of samples. The stimulus changes every input two time units after a rising edge and holds the error input low during reset. Pulse widths are placed exactly on and one cycle past each limit. The tick period and hold count are shortened by parameter so that hold lengths and retriggering fit in short windows.

// File: rtl/ped_pkg.sv
package ped_pkg;

    typedef enum logic [1:0] {
        SEL_STOP   = 2'b00,
        SEL_PASS   = 2'b01,
        SEL_NARROW = 2'b10,
        SEL_WIDE   = 2'b11
    } width_sel_e;

    typedef enum logic [1:0] {
        M_IDLE    = 2'd0,
        M_MEASURE = 2'd1,
        M_OVER    = 2'd2
    } meter_state_e;

    typedef enum logic {
        S_QUIET = 1'b0,
        S_HOLD  = 1'b1
    } stretch_state_e;

endpackage

// File: rtl/ped_sync.sv
module ped_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i};
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/ped_width_meter.sv
module ped_width_meter
    import ped_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             err_i,
    input  logic [CNT_W-1:0] thr_i,
    output logic             viol_o
);

    meter_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             viol_q, viol_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= M_IDLE;
            cnt_q   <= '0;
            viol_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            viol_q  <= viol_d;
        end
    end

    // next state: cnt holds the number of high samples already seen
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        viol_d  = 1'b0;
        if (!en_i) begin
            state_d = M_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                M_IDLE: begin
                    if (err_i) begin
                        state_d = M_MEASURE;
                        cnt_d   = CNT_W'(1);
                    end
                end
                M_MEASURE: begin
                    if (!err_i) begin
                        state_d = M_IDLE;
                        cnt_d   = '0;
                    end else if (cnt_q >= thr_i) begin
                        state_d = M_OVER;
                        viol_d  = 1'b1;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
                M_OVER: begin
                    if (!err_i) begin
                        state_d = M_IDLE;
                        cnt_d   = '0;
                    end
                end
                default: begin
                    state_d = M_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        viol_o = viol_q;
    end

    // R3: a pulse still inside the limit never raises the strobe
    p_no_early_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && state_q == M_MEASURE && cnt_q < thr_i) |=> !viol_o);

    // R4: once flagged, the meter waits out the rest of the pulse without a second strobe
    p_over_waits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && state_q == M_OVER && err_i) |=> (state_q == M_OVER && !viol_o));

endmodule

// File: rtl/ped_stretcher.sv
module ped_stretcher
    import ped_pkg::*;
#(
    parameter int TICK_DIV      = 100000,
    parameter int STRETCH_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic viol_i,
    output logic held_o
);

    localparam int DIV_W = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam int TK_W  = $clog2(STRETCH_TICKS + 1);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(TICK_DIV - 1);
    localparam logic [TK_W-1:0]  TK_FULL  = TK_W'(STRETCH_TICKS);

    logic [DIV_W-1:0] div_q;
    logic             tick;

    stretch_state_e  state_q, state_d;
    logic [TK_W-1:0] left_q, left_d;

    // free-running slow tick
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (div_q == DIV_LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + DIV_W'(1);
        end
    end

    assign tick = (div_q == DIV_LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_QUIET;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            left_q  <= left_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        left_d  = left_q;
        if (!en_i) begin
            state_d = S_QUIET;
            left_d  = '0;
        end else begin
            unique case (state_q)
                S_QUIET: begin
                    if (viol_i) begin
                        state_d = S_HOLD;
                        left_d  = TK_FULL;
                    end
                end
                S_HOLD: begin
                    if (viol_i) begin
                        left_d = TK_FULL;
                    end else if (tick) begin
                        if (left_q <= TK_W'(1)) begin
                            state_d = S_QUIET;
                            left_d  = '0;
                        end else begin
                            left_d = left_q - TK_W'(1);
                        end
                    end
                end
                default: begin
                    state_d = S_QUIET;
                    left_d  = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        held_o = (state_q == S_HOLD);
    end

    // R6: every violation leaves a full budget behind it
    p_retrigger_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && viol_i) |=> (state_q == S_HOLD && left_q == TK_FULL));

    // R1: leaving the tolerance modes drops any hold at once
    p_stop_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (state_q == S_QUIET && !held_o));

    // R5: the remaining budget in a hold is never empty nor over full
    p_budget_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HOLD) |-> (left_q >= TK_W'(1) && left_q <= TK_FULL));

    // R5: without a tick or a violation the hold budget does not move
    p_budget_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && state_q == S_HOLD && !tick && !viol_i) |=> $stable(left_q));

endmodule

// File: rtl/phase_lock_detector.sv
module phase_lock_detector
    import ped_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 10000,
    parameter int NARROW_TOL_PS = 550000,
    parameter int WIDE_TOL_PS   = 1110000,
    parameter int TICK_DIV      = 100000,
    parameter int STRETCH_TICKS = 2,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       phase_err_i,
    input  logic [1:0] width_sel_i,
    output logic       unlock_o,
    output logic       lock_status_o
);

    localparam int NARROW_CYC = NARROW_TOL_PS / CLK_PERIOD_PS;
    localparam int WIDE_CYC   = WIDE_TOL_PS / CLK_PERIOD_PS;
    localparam int MAX_CYC    = (WIDE_CYC > NARROW_CYC) ? WIDE_CYC : NARROW_CYC;
    localparam int CNT_W      = $clog2(MAX_CYC + 2);
    localparam logic [CNT_W-1:0] NARROW_THR = CNT_W'(NARROW_CYC);
    localparam logic [CNT_W-1:0] WIDE_THR   = CNT_W'(WIDE_CYC);

    width_sel_e       mode;
    logic             err_s;
    logic             tol_en;
    logic [CNT_W-1:0] thr;
    logic             viol;
    logic             held;

    assign mode   = width_sel_e'(width_sel_i);
    assign tol_en = (mode == SEL_NARROW) || (mode == SEL_WIDE);
    assign thr    = (mode == SEL_WIDE) ? WIDE_THR : NARROW_THR;

    ped_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (phase_err_i),
        .q_o   (err_s)
    );

    ped_width_meter #(.CNT_W(CNT_W)) meter_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (tol_en),
        .err_i  (err_s),
        .thr_i  (thr),
        .viol_o (viol)
    );

    ped_stretcher #(
        .TICK_DIV      (TICK_DIV),
        .STRETCH_TICKS (STRETCH_TICKS)
    ) stretch_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (tol_en),
        .viol_i (viol),
        .held_o (held)
    );

    // output selection by mode
    always_comb begin
        unique case (mode)
            SEL_STOP:   unlock_o = 1'b0;
            SEL_PASS:   unlock_o = err_s;
            SEL_NARROW: unlock_o = held;
            SEL_WIDE:   unlock_o = held;
            default:    unlock_o = 1'b0;
        endcase
        lock_status_o = ~unlock_o;
    end

    // R1: a violation strobe can only come from a tolerance mode held for a cycle
    p_strobe_needs_tol_r1: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> $past(tol_en));

endmodule

// File: tb/phase_lock_detector_tb_top.sv
module phase_lock_detector_tb_top;

    localparam int TB_DIV     = 40;
    localparam int TB_STRETCH = 3;
    localparam int HOLD_LO    = (TB_STRETCH - 1) * TB_DIV + 1;
    localparam int HOLD_HI    = TB_STRETCH * TB_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       perr = 1'b0;
    logic [1:0] wsel = 2'b00;
    logic       unlock;
    logic       status;

    typedef struct {
        string tag;
        int    lo;
        int    hi;
    } exp_t;

    exp_t sb_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   close_req = 1'b0;
    int   high_cnt = 0;
    bit   status_bad = 1'b0;
    bit   finished = 1'b0;

    always #5 clk = ~clk;

    phase_lock_detector #(
        .TICK_DIV      (TB_DIV),
        .STRETCH_TICKS (TB_STRETCH)
    ) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .phase_err_i   (perr),
        .width_sel_i   (wsel),
        .unlock_o      (unlock),
        .lock_status_o (status)
    );

    // monitor: counts unlock cycles per window, compares with scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (unlock === 1'b1) high_cnt++;
            if (status !== ~unlock) status_bad = 1'b1;
            if (close_req) begin
                exp_t e;
                checks++;
                if (sb_q.size() == 0) begin
                    errors++;
                    $display("FAIL scoreboard: actual empty queue, expected an item");
                end else begin
                    e = sb_q.pop_front();
                    if (high_cnt < e.lo || high_cnt > e.hi) begin
                        errors++;
                        $display("FAIL %s: actual %0d unlock cycles, expected %0d..%0d",
                                 e.tag, high_cnt, e.lo, e.hi);
                    end
                end
                checks++;
                if (status_bad) begin
                    errors++;
                    $display("FAIL R7 status inverse: actual mismatch seen, expected status == ~unlock");
                end
                high_cnt   = 0;
                status_bad = 1'b0;
                close_req  = 1'b0;
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic close_window();
        close_req = 1'b1;
        wait (close_req == 1'b0);
        step(1);
    endtask

    task automatic pulse(input int w);
        if (w > 0) begin
            perr = 1'b1;
            step(w);
            perr = 1'b0;
        end
    endtask

    task automatic run_item(input string tag, input logic [1:0] sel,
                            input int w, input int lo, input int hi);
        wsel = sel;
        step(5);
        sb_q.push_back('{tag, lo, hi});
        pulse(w);
        step(250);
        close_window();
    endtask

    initial begin
        // R8: reset state
        repeat (3) @(negedge clk);
        checks++;
        if (unlock !== 1'b0 || status !== 1'b1) begin
            errors++;
            $display("FAIL R8 in reset: actual unlock=%b status=%b, expected 0 1", unlock, status);
        end
        step(1);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (unlock !== 1'b0 || status !== 1'b1) begin
            errors++;
            $display("FAIL R8 after reset: actual unlock=%b status=%b, expected 0 1", unlock, status);
        end
        step(1);

        // R1: stop mode ignores a long error
        run_item("R1 stop ignores pulse", 2'b00, 200, 0, 0);

        // R2: pass-through widths
        run_item("R2 pass width 1", 2'b01, 1, 1, 1);
        run_item("R2 pass width 3", 2'b01, 3, 3, 3);
        run_item("R2 pass width 70", 2'b01, 70, 70, 70);

        // R3: narrow limit boundary
        run_item("R3 narrow at limit", 2'b10, 55, 0, 0);
        run_item("R3 narrow over limit", 2'b10, 56, HOLD_LO, HOLD_HI);
        run_item("R3 narrow short", 2'b10, 5, 0, 0);

        // R4: wide limit boundary
        run_item("R4 wide at limit", 2'b11, 111, 0, 0);
        run_item("R4 wide mid", 2'b11, 70, 0, 0);
        run_item("R4 wide over limit", 2'b11, 112, HOLD_LO, HOLD_HI);

        // R5: single hold length
        run_item("R5 hold length narrow", 2'b10, 90, HOLD_LO, HOLD_HI);

        // R6: retrigger, two over-limit pulses 59 cycles apart
        wsel = 2'b10;
        step(5);
        sb_q.push_back('{"R6 retrigger extends hold", 59 + HOLD_LO, 59 + HOLD_HI});
        pulse(57);
        step(2);
        pulse(57);
        step(300);
        close_window();

        // R1: entering stop during a hold ends it, no residue afterwards
        wsel = 2'b10;
        step(5);
        sb_q.push_back('{"R1 stop cuts hold", 1, 30});
        pulse(60);
        step(10);
        wsel = 2'b00;
        step(250);
        close_window();
        run_item("R1 no residue after stop", 2'b10, 0, 0, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual run still busy, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule